// File: doc/BRIEF.md
# Serial Clock Configuration Register Slave

This block is the write-only two-wire serial slave of a clock generator. A bus master writes to it with a fixed transfer layout. First comes the device address with the write direction bit. Next come a command byte and a count byte, which the slave acknowledges and then ignores. Last come data bytes, which fill the configuration registers in order, starting at register 0. The two registers hold the clock generator's configuration. The slave decodes them into the operating mode, the frequency-select source and value, the CPU clock pair enable, the SDRAM clock enable and the spread-bandwidth select.

SCL and SDA pass through two synchroniser flip-flops into the system clock domain, and all bus edges are detected there. The slave pulls SDA low only during the acknowledge clock. The registers take their defaults only from the power-up reset. A bus transfer never restores them, so settings persist across aborted or malformed transfers.

Control outputs follow a register write one system clock after the acknowledge decision. They are plain levels with no handshake. The block has no streaming interface, so there is no back-pressure: the bus master sets the pace through SCL.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: The slave acknowledges only the address byte carrying 7-bit address 0x69 with direction bit 0 (write). Any other address, or direction bit 1, gets no acknowledge, and the slave ignores the bus until the next START.
- R2: After an acknowledged address, the next two bytes (command and count) are acknowledged, and their values change no register or output.
- R3: Data bytes that follow are acknowledged and stored in order: the first into register 0, the second into register 1.
- R4: Power-up reset sets register 0 to 0x80 and register 1 to 0x0B. Registers change only on a data-byte write.
- R5: A START or STOP at any point ends the current transfer and returns the byte pointer to register 0. Bytes already completed stay stored, and a partly received byte is dropped.
- R6: Data bytes beyond register 1 are acknowledged and discarded.
- R7: `mode` = {reg0 bit 7, reg0 bit 0}. 00 is normal, 01 is tri-state (`tristate_en`), 10 is spread on (`spread_en`), and 11 is test (`test_en` and `spread_en`).
- R8: When reg0 bit 3 is 1, `fsel[4:0]` = {reg0[2], reg0[1], reg0[6], reg0[5], reg0[4]}. When it is 0, `fsel` equals `hw_fsel` in the same cycle.
- R9: `cpu_en` = reg1 bit 1 and `cpu_comp_hiz` = NOT reg1 bit 1. A disabled CPU output is held low, and its complement is placed in high impedance.
- R10: `spread_bw` = reg1 bits 7:5, and `sdram_en` = reg1 bit 3. Reserved bits drive no output.
- R11: `sda_drive_low` is asserted only from the falling SCL edge ending an acknowledged byte's eighth bit until the falling edge ending the ninth clock. It is never asserted during data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_drive_low | output | 1 | Open-drain pull-down request for SDA |
| hw_fsel | input | 5 | Hardware frequency-select inputs |
| mode | output | 2 | Decoded operating mode |
| tristate_en | output | 1 | Outputs tri-stated |
| spread_en | output | 1 | Spread spectrum on |
| test_en | output | 1 | Test mode |
| fsel | output | 5 | Effective frequency select |
| fsel_sw | output | 1 | Software frequency select active |
| cpu_en | output | 1 | CPU clock pair running |
| cpu_comp_hiz | output | 1 | Complementary CPU output high impedance |
| sdram_en | output | 1 | SDRAM clock enabled |
| spread_bw | output | 3 | Spread-bandwidth select |

## Verification
A register write can land in the same system cycle as a change on the hardware frequency-select pins. That write may also flip the source bit that chooses between the software and hardware selects. To provoke this, the bench changes `hw_fsel` to a new random value every cycle throughout randomized transfers, so writes to register 0 repeatedly coincide with a changing pin value. After each transfer, it judges `fsel` against a bench function of the modelled register and the current pin value. Aborts by a repeated START in mid-byte are mixed in, so that pointer reset and retained bytes are checked together.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_DATA
  } bus_state_t;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'b00,
    MODE_TRISTATE = 2'b01,
    MODE_SPREAD   = 2'b10,
    MODE_TEST     = 2'b11
  } clk_mode_t;

  localparam int BYTE_W = 8;

  function automatic logic [BYTE_W-1:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h80;
      1:       return 8'h0B;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/clkcfg_sync_edge.sv
module clkcfg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      last  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~last;
  assign fall = ~lvl & last;
endmodule

// File: rtl/clkcfg_bus_fsm.sv
module clkcfg_bus_fsm
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 2,
  localparam int        IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int        PTR_W    = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_drive_low
);
  bus_state_t        state;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [PTR_W-1:0]  ptr;
  logic              start_c, stop_c, addr_hit;

  assign start_c  = sda_fall & scl_lvl;
  assign stop_c   = sda_rise & scl_lvl;
  assign addr_hit = (shreg[7:1] == DEV_ADDR) && !shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      bitcnt        <= '0;
      shreg         <= '0;
      ptr           <= '0;
      sda_drive_low <= 1'b0;
      wr_en         <= 1'b0;
      wr_idx        <= '0;
      wr_data       <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        state         <= ST_ADDR;
        bitcnt        <= '0;
        ptr           <= '0;
        sda_drive_low <= 1'b0;
      end else if (stop_c) begin
        state         <= ST_IDLE;
        bitcnt        <= '0;
        ptr           <= '0;
        sda_drive_low <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (state)
              ST_ADDR: begin
                if (addr_hit) sda_drive_low <= 1'b1;
                else begin
                  state  <= ST_IDLE;
                  bitcnt <= '0;
                end
              end
              ST_DATA: begin
                sda_drive_low <= 1'b1;
                if (ptr < PTR_W'(NUM_REGS)) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr[IDX_W-1:0];
                  wr_data <= shreg;
                  ptr     <= ptr + 1'b1;
                end
              end
              default: sda_drive_low <= 1'b1;
            endcase
          end else if (bitcnt == 4'd9) begin
            sda_drive_low <= 1'b0;
            bitcnt        <= '0;
            case (state)
              ST_ADDR: state <= ST_CMD;
              ST_CMD:  state <= ST_CNT;
              default: state <= ST_DATA;
            endcase
          end
        end
      end
    end
  end

  // R1: a wrong address or a read request is not acknowledged
  a_r1_nack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && scl_fall && bitcnt == 4'd8 && !addr_hit && !start_c && !stop_c)
      |=> (state == ST_IDLE && !sda_drive_low));

  // R11: the pull-down appears only inside the acknowledge window
  a_r11_ack_window: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low |-> (bitcnt >= 4'd8));

  // R5: STOP ends the transfer and returns the pointer
  a_r5_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state == ST_IDLE && ptr == '0 && !sda_drive_low));

  // R6: the pointer never runs past the register count
  a_r6_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(NUM_REGS));
endmodule

// File: rtl/clkcfg_reg_bank.sv
module clkcfg_reg_bank
  import clkcfg_pkg::*;
#(
  parameter int  NUM_REGS = 2,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [BYTE_W-1:0]                 wr_data,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]   regs
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  regs[g] <= reg_default(g);
      else if (wr_en && wr_idx == IDX_W'(g))       regs[g] <= wr_data;
    end
  end

  // R4: registers hold their value unless a data byte is written
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));
endmodule

// File: rtl/clkcfg_decode.sv
module clkcfg_decode
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] ctl0,
  input  logic [BYTE_W-1:0] ctl1,
  input  logic [4:0]        hw_fsel,
  output logic [1:0]        mode,
  output logic              tristate_en,
  output logic              spread_en,
  output logic              test_en,
  output logic [4:0]        fsel,
  output logic              fsel_sw,
  output logic              cpu_en,
  output logic              cpu_comp_hiz,
  output logic              sdram_en,
  output logic [2:0]        spread_bw
);
  clk_mode_t m;

  assign m           = clk_mode_t'({ctl0[7], ctl0[0]});
  assign mode        = m;
  assign tristate_en = (m == MODE_TRISTATE);
  assign spread_en   = (m == MODE_SPREAD) || (m == MODE_TEST);
  assign test_en     = (m == MODE_TEST);
  assign fsel_sw     = ctl0[3];
  assign fsel        = fsel_sw ? {ctl0[2], ctl0[1], ctl0[6], ctl0[5], ctl0[4]} : hw_fsel;
  assign cpu_en      = ctl1[1];
  assign cpu_comp_hiz = ~ctl1[1];
  assign sdram_en    = ctl1[3];
  assign spread_bw   = ctl1[7:5];

  // R7: test mode always carries spread spectrum
  a_r7_test_spread: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |-> spread_en);

  // R7: tri-state and spread spectrum never coexist
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tristate_en && spread_en));
endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 2,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_drive_low,
  input  logic [4:0] hw_fsel,
  output logic [1:0] mode,
  output logic       tristate_en,
  output logic       spread_en,
  output logic       test_en,
  output logic [4:0] fsel,
  output logic       fsel_sw,
  output logic       cpu_en,
  output logic       cpu_comp_hiz,
  output logic       sdram_en,
  output logic [2:0] spread_bw
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic                            wr_en;
  logic [IDX_W-1:0]                wr_idx;
  logic [BYTE_W-1:0]               wr_data;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs;

  clkcfg_sync_edge #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));

  clkcfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  clkcfg_bus_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_drive_low(sda_drive_low));

  clkcfg_reg_bank #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .regs(regs));

  clkcfg_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .ctl0(regs[0]), .ctl1(regs[1]), .hw_fsel(hw_fsel),
    .mode(mode), .tristate_en(tristate_en), .spread_en(spread_en), .test_en(test_en),
    .fsel(fsel), .fsel_sw(fsel_sw), .cpu_en(cpu_en), .cpu_comp_hiz(cpu_comp_hiz),
    .sdram_en(sdram_en), .spread_bw(spread_bw));
endmodule

// File: tb/tb_clkcfg_serial_slave.sv
`timescale 1ns/1ps
module tb_clkcfg_serial_slave;
  localparam int HP = 10;
  localparam logic [6:0] ADDR = 7'h69;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1, jit = 1'b0;
  logic [4:0] hw_fsel = 5'd0;
  logic       sda_line, sda_drive_low;
  logic [1:0] mode;
  logic       tristate_en, spread_en, test_en, fsel_sw, cpu_en, cpu_comp_hiz, sdram_en;
  logic [4:0] fsel;
  logic [2:0] spread_bw;

  assign sda_line = sda_m & ~sda_drive_low;

  clkcfg_serial_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_drive_low(sda_drive_low),
    .hw_fsel(hw_fsel), .mode(mode), .tristate_en(tristate_en), .spread_en(spread_en),
    .test_en(test_en), .fsel(fsel), .fsel_sw(fsel_sw), .cpu_en(cpu_en),
    .cpu_comp_hiz(cpu_comp_hiz), .sdram_en(sdram_en), .spread_bw(spread_bw));

  int n_cmp = 0, n_bad = 0, spurious = 0;
  logic       done = 1'b0;
  logic [7:0] m0, m1;
  logic [7:0] dbuf [8];

  always begin
    @(posedge clk); #1;
    if (jit) hw_fsel = 5'($urandom);
  end

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [4:0] exp_fsel(input logic [7:0] r0, input logic [4:0] hw);
    return r0[3] ? {r0[2], r0[1], r0[6], r0[5], r0[4]} : hw;
  endfunction

  task automatic check_outputs(input string req);
    @(negedge clk);
    check("R7", {req, " mode"}, 32'(mode), 32'({m0[7], m0[0]}));
    check("R7", {req, " modebits"}, 32'({tristate_en, spread_en, test_en}),
          32'({!m0[7] && m0[0], m0[7], m0[7] && m0[0]}));
    check("R8", {req, " fsel"}, 32'({fsel_sw, fsel}), 32'({m0[3], exp_fsel(m0, hw_fsel)}));
    check("R9", {req, " cpu"}, 32'({cpu_en, cpu_comp_hiz}), 32'({m1[1], !m1[1]}));
    check("R10", {req, " sdram/bw"}, 32'({sdram_en, spread_bw}), 32'({m1[3], m1[7:5]}));
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(HP); scl_m = 1'b1; wt(HP); sda_m = 1'b0; wt(HP); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HP); scl_m = 1'b1; wt(HP); sda_m = 1'b1; wt(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(HP);
      if (sda_drive_low) spurious++;
      scl_m = 1'b1; wt(HP); scl_m = 1'b0;
    end
    sda_m = 1'b1; wt(HP); scl_m = 1'b1; wt(HP/2);
    acked = ~sda_line;
    wt(HP/2); scl_m = 1'b0;
  endtask

  task automatic txn(input logic [6:0] a, input logic rw, input int n, input int cut_bits);
    logic ak, exp_a;
    exp_a = (a == ADDR) && !rw;
    bus_start();
    send_byte({a, rw}, ak);
    check("R1", "address ack", 32'(ak), 32'(exp_a));
    if (!exp_a) begin bus_stop(); return; end
    send_byte(8'($urandom), ak); check("R2", "command ack", 32'(ak), 1);
    send_byte(8'($urandom), ak); check("R2", "count ack", 32'(ak), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(dbuf[i], ak);
      check(i >= 2 ? "R6" : "R3", "data ack", 32'(ak), 1);
      if (i == 0) m0 = dbuf[0];
      if (i == 1) m1 = dbuf[1];
    end
    if (cut_bits > 0) begin
      for (int j = 0; j < cut_bits; j++) begin
        sda_m = 1'($urandom); wt(HP); scl_m = 1'b1; wt(HP); scl_m = 1'b0;
      end
      bus_start();
    end
    bus_stop();
  endtask

  initial begin
    void'($urandom(32'h5A17));
    m0 = 8'h80; m1 = 8'h0B;
    wt(5); rst_n = 1'b1; wt(5);
    hw_fsel = 5'h15;
    check_outputs("R4 reset");
    check("R11", "idle drive", 32'(sda_drive_low), 0);

    // R3 directed write of both registers, software select on
    dbuf[0] = 8'b0101_1011; dbuf[1] = 8'b1010_1000;
    txn(ADDR, 1'b0, 2, 0); check_outputs("R3 write");

    // R1 wrong address and read request
    dbuf[0] = 8'hFF; dbuf[1] = 8'hFF;
    txn(7'h68, 1'b0, 2, 0); check_outputs("R1 wrong addr");
    txn(ADDR, 1'b1, 2, 0);  check_outputs("R1 read");

    // R2 only command and count
    txn(ADDR, 1'b0, 0, 0); check_outputs("R2 no data");

    // R6 extra bytes discarded
    dbuf[0] = 8'h81; dbuf[1] = 8'h02; dbuf[2] = 8'hFF; dbuf[3] = 8'h00;
    txn(ADDR, 1'b0, 4, 0); check_outputs("R6 overflow");

    // R5 abort mid-byte: register 1 keeps its value
    dbuf[0] = 8'h08;
    txn(ADDR, 1'b0, 1, 5); check_outputs("R5 abort");
    // R5 pointer restarts at register 0
    dbuf[0] = 8'h01;
    txn(ADDR, 1'b0, 1, 0); check_outputs("R5 restart");

    // random mix with hw_fsel changing every cycle
    jit = 1'b1;
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < 8; i++) dbuf[i] = 8'($urandom);
      txn(($urandom % 8 == 0) ? 7'($urandom) : ADDR, ($urandom % 10 == 0),
          int'($urandom % 5), ($urandom % 4 == 0) ? int'($urandom % 8) : 0);
      check_outputs("random");
    end
    jit = 1'b0;
    check("R11", "drive outside ack", 32'(spurious), 0);
    check("R11", "released at end", 32'(sda_drive_low), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule